// File: doc/BRIEF.md
# SEC-DED Check and Correct Unit for 32-bit Words

This block protects a 32-bit data word with a 7-bit check word. On the store side it turns a data word into its check word. On the load side it takes the 39 stored bits and returns several results. It gives a 7-bit syndrome, which points to the failing position. It returns the data word with any single flipped data bit restored. It also raises two active-low flags: one for any detected error and one for errors it cannot correct.

The code uses odd-weight parity columns. Each data bit feeds three or five check bits, and each check bit is the parity of exactly sixteen data bits. A fixed inversion applied to check bits 0 and 2 means that stored words of all zeros or all ones never decode as clean. Both paths are computed from the same input cycle. The results are presented one clock later, qualified by a valid strobe.

Top module: `ecc32_secded`

## Requirements
- R1: `wr_check` is the parity of each check bit's data group, with check bits 0 and 2 inverted, so that data `32'h0` and data `32'hFFFFFFFF` both encode to `7'h05`.
- R2: Every check bit covers exactly 16 data bits. Flipping any one data bit changes 3 or 5 check bits. The 32 change patterns are all distinct.
- R3: A stored word with no error gives syndrome 0, `err_n`=1 and `merr_n`=1, and `corr_data` equals `rd_data`.
- R4: A single data bit error gives a syndrome equal to that bit's change pattern from R2, with `err_n`=0 and `merr_n`=1. `corr_data` returns the original data.
- R5: A single check bit error k gives the one-hot syndrome `1<<k`, with `err_n`=0 and `merr_n`=1. `corr_data` equals the received data unchanged.
- R6: Any two errors among the 39 bits give a nonzero even-weight syndrome equal to the XOR of the two single-error syndromes. Both flags are 0 and the received data passes uncorrected.
- R7: An all-zero 39-bit word gives syndrome `7'h05` and an all-one word gives syndrome `7'h7A`. Both are flagged with both flags 0, and the data passes unchanged.
- R8: An odd-weight syndrome that is neither one-hot nor a data bit pattern is reported as uncorrectable: both flags 0 and no data bit flipped.
- R9: Outputs are registered. The inputs sampled on a clock edge with `in_valid`=1 appear after that edge with `out_valid`=1. On an edge with `in_valid`=0, `out_valid` drops and all other outputs hold.
- R10: During reset `out_valid`=0, `err_n`=1, `merr_n`=1, and `wr_check`, `syndrome` and `corr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Inputs are sampled on this edge |
| wr_data | input | 32 | Data word to encode |
| wr_check | output | 7 | Check word for the sampled `wr_data` |
| rd_data | input | 32 | Data part of the stored word |
| rd_check | input | 7 | Check part of the stored word |
| out_valid | output | 1 | Registered results are from the last sampled inputs |
| syndrome | output | 7 | Syndrome of the stored word |
| corr_data | output | 32 | Data word after correction |
| err_n | output | 1 | Low when any error is detected |
| merr_n | output | 1 | Low when the error cannot be corrected |

## Verification
The bench first learns each data bit's check pattern through the encoder alone. It then injects every single and every pair of flips across all 39 bits on several data words, and predicts the syndrome by linearity. If the decoder treated a check-bit error as a data error, it would flip a data bit on R5 cases. If it corrected even-weight syndromes, it would corrupt data on R6 cases. If it dropped the inversion mask, it would report all-zero memory as clean. The bench also builds a non-column odd syndrome: a decoder that guessed a nearest bit for it would alter data on R8. Hold and latency are checked with `in_valid` low while the inputs change.

// File: rtl/ecc32_pkg.sv
package ecc32_pkg;

  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;
  localparam int N_W5   = 8;
  localparam int N_W3   = DATA_W - N_W5;
  localparam int N_CODE = 1 << CHK_W;

  // inversion keeps all-zero and all-one stored words away from clean
  localparam logic [CHK_W-1:0] CHK_INV = 7'h05;

  typedef logic [CHK_W-1:0] col_t;
  typedef col_t col_arr_t [DATA_W];

  function automatic int unsigned col_weight(col_t v);
    int unsigned n;
    n = 0;
    for (int b = 0; b < CHK_W; b++) n += 32'(v[b]);
    return n;
  endfunction

  // weight-3 codes left out so every row ends at sixteen data bits
  function automatic bit w3_unused(col_t v);
    case (v)
      7'h0B, 7'h16, 7'h2C, 7'h58, 7'h31, 7'h62,
      7'h45, 7'h07, 7'h32, 7'h4C, 7'h70: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  function automatic col_t w5_code(int k);
    case (k)
      0:       return 7'h7C;
      1:       return 7'h79;
      2:       return 7'h73;
      3:       return 7'h67;
      4:       return 7'h4F;
      5:       return 7'h1F;
      6:       return 7'h3E;
      default: return 7'h76;
    endcase
  endfunction

  function automatic col_arr_t build_cols();
    col_arr_t    c;
    int unsigned n;
    n = 0;
    for (int k = 0; k < DATA_W; k++) c[k] = '0;
    for (int v = 1; v < N_CODE; v++) begin
      if (col_weight(col_t'(v)) == 3 && !w3_unused(col_t'(v)) && n < N_W3) begin
        c[n] = col_t'(v);
        n++;
      end
    end
    for (int k = 0; k < N_W5; k++) c[N_W3+k] = w5_code(k);
    return c;
  endfunction

  localparam col_arr_t H_COLS = build_cols();

  function automatic logic [DATA_W-1:0] row_mask(int r);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = H_COLS[i][r];
    return m;
  endfunction

endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/ecc_parity_tree.sv
module ecc_parity_tree
  import ecc32_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  par_o
);

  for (genvar r = 0; r < CHK_W; r++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = row_mask(r);
    assign par_o[r] = ^(data_i & MASK);
  end

endmodule

// File: rtl/ecc_syn_decode.sv
module ecc_syn_decode
  import ecc32_pkg::*;
(
  input  col_t              syn_i,
  output logic [DATA_W-1:0] flip_o,
  output logic              single_o,
  output logic              multi_o
);

  logic [DATA_W-1:0] hit;
  logic              nonzero;
  logic              unit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    assign hit[i] = (syn_i == H_COLS[i]);
  end

  assign nonzero  = |syn_i;
  assign unit     = nonzero && ((syn_i & (syn_i - col_t'(1))) == '0);
  assign single_o = (|hit) || unit;
  assign multi_o  = nonzero && !single_o;
  assign flip_o   = hit;

endmodule

// File: rtl/ecc_correct.sv
module ecc_correct
  import ecc32_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] flip_i,
  input  logic              single_i,
  input  logic              multi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_n_o,
  output logic              merr_n_o
);

  assign data_o   = data_i ^ flip_i;
  assign err_n_o  = !(single_i || multi_i);
  assign merr_n_o = !multi_i;

endmodule

// File: rtl/ecc32_secded.sv
module ecc32_secded
  import ecc32_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CHK_W-1:0]  wr_check,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_check,
  output logic              out_valid,
  output logic [CHK_W-1:0]  syndrome,
  output logic [DATA_W-1:0] corr_data,
  output logic              err_n,
  output logic              merr_n
);

  logic rst_s_n;

  ecc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  // store path
  logic [CHK_W-1:0] wr_par;
  ecc_parity_tree u_wr_tree (
    .data_i (wr_data),
    .par_o  (wr_par)
  );

  // load path
  logic [CHK_W-1:0]  rd_par;
  logic [CHK_W-1:0]  syn_c;
  logic [DATA_W-1:0] flip_c;
  logic              single_c, multi_c;
  logic [DATA_W-1:0] fix_c;
  logic              err_n_c, merr_n_c;

  ecc_parity_tree u_rd_tree (
    .data_i (rd_data),
    .par_o  (rd_par)
  );

  assign syn_c = rd_par ^ CHK_INV ^ rd_check;

  ecc_syn_decode u_dec (
    .syn_i    (syn_c),
    .flip_o   (flip_c),
    .single_o (single_c),
    .multi_o  (multi_c)
  );

  ecc_correct u_fix (
    .data_i   (rd_data),
    .flip_i   (flip_c),
    .single_i (single_c),
    .multi_i  (multi_c),
    .data_o   (fix_c),
    .err_n_o  (err_n_c),
    .merr_n_o (merr_n_c)
  );

  // output registers: next-state then flops
  logic              vld_q, vld_d;
  logic [CHK_W-1:0]  wchk_q, wchk_d;
  logic [CHK_W-1:0]  syn_q, syn_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              errn_q, errn_d;
  logic              merrn_q, merrn_d;

  always_comb begin
    vld_d   = in_valid;
    wchk_d  = wchk_q;
    syn_d   = syn_q;
    dat_d   = dat_q;
    errn_d  = errn_q;
    merrn_d = merrn_q;
    if (in_valid) begin
      wchk_d  = wr_par ^ CHK_INV;
      syn_d   = syn_c;
      dat_d   = fix_c;
      errn_d  = err_n_c;
      merrn_d = merr_n_c;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_q   <= 1'b0;
      wchk_q  <= '0;
      syn_q   <= '0;
      dat_q   <= '0;
      errn_q  <= 1'b1;
      merrn_q <= 1'b1;
    end else begin
      vld_q   <= vld_d;
      wchk_q  <= wchk_d;
      syn_q   <= syn_d;
      dat_q   <= dat_d;
      errn_q  <= errn_d;
      merrn_q <= merrn_d;
    end
  end

  assign out_valid = vld_q;
  assign wr_check  = wchk_q;
  assign syndrome  = syn_q;
  assign corr_data = dat_q;
  assign err_n     = errn_q;
  assign merr_n    = merrn_q;

  // checks on the registered results
  p_clean_flags_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && syndrome == '0) |-> (err_n && merr_n));

  p_single_flip_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> ($countones(corr_data ^ $past(rd_data)) <= 1));

  p_check_err_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && $countones(syndrome) == 1) |->
      (corr_data == $past(rd_data) && !err_n && merr_n));

  p_even_uncorr_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && syndrome != '0 && !(^syndrome)) |-> !merr_n);

  p_flag_order_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !merr_n |-> !err_n);

  p_uncorr_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !merr_n) |-> (corr_data == $past(rd_data)));

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> out_valid);

  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> (!out_valid && $stable(corr_data) && $stable(syndrome)));

endmodule

// File: tb/sim_ecc32_secded.sv
module sim_ecc32_secded;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [6:0]  rd_check;
  logic [6:0]  wr_check;
  logic        out_valid;
  logic [6:0]  syndrome;
  logic [31:0] corr_data;
  logic        err_n;
  logic        merr_n;

  int total;
  int bad;

  ecc32_secded u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .wr_data   (wr_data),
    .wr_check  (wr_check),
    .rd_data   (rd_data),
    .rd_check  (rd_check),
    .out_valid (out_valid),
    .syndrome  (syndrome),
    .corr_data (corr_data),
    .err_n     (err_n),
    .merr_n    (merr_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    string       req;
    logic [6:0]  syn;
    logic [31:0] data;
    logic        e_n;
    logic        m_n;
  } exp_t;

  exp_t        expq[$];
  exp_t        cur;
  logic [6:0]  col [32];
  logic [6:0]  c0, c1, ci, cw_chk, odd_syn;
  logic [31:0] d;
  logic [38:0] cw, rx;
  int          rowcnt [7];
  int          dups;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference queue compared whenever a result is presented
  always @(negedge clk) begin
    if (out_valid === 1'b1) begin
      if (expq.size() == 0) chk("R9", "valid with nothing pending", 64'd1, 64'd0);
      else begin
        cur = expq.pop_front();
        chk(cur.req, "syndrome", 64'(syndrome),  64'(cur.syn));
        chk(cur.req, "data",     64'(corr_data), 64'(cur.data));
        chk(cur.req, "err_n",    64'(err_n),     64'(cur.e_n));
        chk(cur.req, "merr_n",   64'(merr_n),    64'(cur.m_n));
      end
    end
  end

  task automatic send(input logic [31:0] wd, input logic [31:0] rdd, input logic [6:0] rc,
                      input string req, input logic [6:0] es, input logic [31:0] ed,
                      input logic ee, input logic em);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    wr_data  = wd;
    rd_data  = rdd;
    rd_check = rc;
    e.req = req; e.syn = es; e.data = ed; e.e_n = ee; e.m_n = em;
    expq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // encode through the store path; load side carries a clean zero word (R1, R3)
  task automatic enc(input logic [31:0] dw, output logic [6:0] cc);
    send(dw, 32'h0, 7'h05, "R3", 7'h00, 32'h0, 1'b1, 1'b1);
    @(posedge clk);
    #1;
    cc = wr_check;
  endtask

  function automatic logic [6:0] s_of(int p);
    if (p < 32) return col[p];
    return 7'(1 << (p - 32));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    wrap_up();
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; in_valid = 1'b0;
    wr_data = '0; rd_data = '0; rd_check = '0;
    repeat (3) @(negedge clk);
    chk("R10", "out_valid in reset", 64'(out_valid), 64'd0);
    chk("R10", "err_n in reset",     64'(err_n),     64'd1);
    chk("R10", "merr_n in reset",    64'(merr_n),    64'd1);
    chk("R10", "syndrome in reset",  64'(syndrome),  64'd0);
    chk("R10", "data in reset",      64'(corr_data), 64'd0);
    chk("R10", "wr_check in reset",  64'(wr_check),  64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: inversion constant on both extreme data words
    enc(32'h0000_0000, c0);
    chk("R1", "check of zero data", 64'(c0), 64'h05);
    enc(32'hFFFF_FFFF, c1);
    chk("R1", "check of all-one data", 64'(c1), 64'h05);

    // R2: learn each data bit's pattern through the store path
    for (int r = 0; r < 7; r++) rowcnt[r] = 0;
    for (int i = 0; i < 32; i++) begin
      enc(32'(1) << i, ci);
      col[i] = ci ^ c0;
      chk("R2", $sformatf("bit %0d pattern weight 3 or 5", i),
          64'($countones(col[i]) == 3 || $countones(col[i]) == 5), 64'd1);
      for (int r = 0; r < 7; r++) rowcnt[r] += int'(col[i][r]);
    end
    for (int r = 0; r < 7; r++)
      chk("R2", $sformatf("row %0d data count", r), 64'(rowcnt[r]), 64'd16);
    dups = 0;
    for (int i = 0; i < 32; i++)
      for (int j = i + 1; j < 32; j++)
        if (col[i] == col[j]) dups++;
    chk("R2", "duplicate patterns", 64'(dups), 64'd0);

    // R3..R6 over several data words
    for (int k = 0; k < 4; k++) begin
      d = (k == 0) ? 32'h8000_0001 : $urandom();
      enc(d, cw_chk);
      cw = {cw_chk, d};
      send(d, d, cw_chk, "R3", 7'h00, d, 1'b1, 1'b1);
      for (int p = 0; p < 39; p++) begin
        rx = cw ^ (39'(1) << p);
        send(d, rx[31:0], rx[38:32], (p < 32) ? "R4" : "R5", s_of(p), d, 1'b0, 1'b1);
      end
      for (int p = 0; p < 39; p++) begin
        for (int q = p + 1; q < 39; q++) begin
          rx = cw ^ (39'(1) << p) ^ (39'(1) << q);
          chk("R6", "pair syndrome even and nonzero",
              64'(($countones(s_of(p) ^ s_of(q)) % 2 == 0) && ((s_of(p) ^ s_of(q)) != 0)), 64'd1);
          send(d, rx[31:0], rx[38:32], "R6", s_of(p) ^ s_of(q), rx[31:0], 1'b0, 1'b0);
        end
      end
    end

    // R7: gross stored words
    send(32'h0, 32'h0000_0000, 7'h00, "R7", 7'h05, 32'h0000_0000, 1'b0, 1'b0);
    send(32'h0, 32'hFFFF_FFFF, 7'h7F, "R7", 7'h7A, 32'hFFFF_FFFF, 1'b0, 1'b0);

    // R8: odd syndrome that is neither one-hot nor a learned pattern
    odd_syn = 7'h00;
    for (int v = 1; v < 128; v++) begin
      if (odd_syn == 7'h00 && ($countones(7'(v)) % 2 == 1) && $countones(7'(v)) > 1) begin
        dups = 0;
        for (int i = 0; i < 32; i++) if (col[i] == 7'(v)) dups++;
        if (dups == 0) odd_syn = 7'(v);
      end
    end
    chk("R8", "non-pattern odd syndrome found", 64'(odd_syn != 7'h00), 64'd1);
    send(32'h0, 32'h0, 7'h05 ^ odd_syn, "R8", odd_syn, 32'h0, 1'b0, 1'b0);

    // R9: outputs hold while in_valid is low
    idle();
    @(negedge clk);
    rd_data  = 32'hFFFF_FFFF;
    rd_check = 7'h00;
    wr_data  = 32'h1234_5678;
    repeat (2) @(negedge clk);
    chk("R9", "valid low while idle", 64'(out_valid), 64'd0);
    chk("R9", "data held",            64'(corr_data), 64'd0);
    chk("R9", "syndrome held",        64'(syndrome),  64'(odd_syn));
    chk("R9", "merr_n held",          64'(merr_n),    64'd0);
    chk("R9", "nothing left pending", 64'(expq.size()), 64'd0);
    wrap_up();
  end

endmodule